// File: doc/BRIEF.md
# Transfer Descriptor Offset Walker

This block steps through a host controller's descriptor buffer and announces where each descriptor starts. Every descriptor is an 8-byte header followed at once by its payload. The walker does not touch memory. It produces a stream of byte offsets and descriptor indices. A downstream fetch engine takes them through a valid/ready handshake.

There are two traversal modes. In fixed-block mode every slot has the same stride: the configured block size plus the 8-byte header. A slot takes its whole stride even when its payload is short. A 16-bit skip map removes chosen slots from the stream. In isochronous mode payload sizes arrive one per descriptor on a handshake input. Each size is rounded up to a multiple of 4 bytes. Offsets accumulate descriptor after descriptor. That walk ends on a last flag, or when the next descriptor would not fit in the configured buffer length.

A buffer-active input gates everything. A walk starts only while it is high. Dropping it mid-walk ends the walk once no output is pending. The next walk then restarts from offset 0.

Top module: `tdWalker`

## Requirements
- R1: After reset, descValid, payReady and walkDone are all 0.
- R2: In fixed-block mode (isoMode=0), descriptor i is presented with descOffset = i*(blockSize+8) and descIndex = i. Descriptors appear in ascending index order. With blockSize 32, index 1 is at offset 40.
- R3: In fixed-block mode, skipMap bit i set to 1 removes descriptor i from the output stream. A map of 0x0011 removes indices 0 and 4.
- R4: A fixed-block walk covers indices 0 to numDesc-1 and then ends. numDesc=0 ends the walk with no descriptor presented.
- R5: In isochronous mode (isoMode=1), descriptor 0 is at offset 0. Descriptor n+1 is at offset(n) + 8 + paySize(n) rounded up to a multiple of 4. Sizes 200, 10, 1023 and 30 give offsets 0, 208, 228 and 1260.
- R6: In isochronous mode, a descriptor whose end (offset + 8 + rounded size) exceeds bufLen is not presented and the walk ends. An end exactly equal to bufLen is presented. payReady and descValid are never high together.
- R7: In isochronous mode, the walk ends after the descriptor whose payload was accepted with payLast=1 has been handed over.
- R8: A start pulse while bufActive is 0 has no effect: no descriptor, no payReady, no walkDone.
- R9: Once descValid is high, it stays high with stable descOffset and descIndex until descReady is seen. This holds even if bufActive falls.
- R10: With bufActive low and no output pending, a running walk stops at once. It presents nothing further and raises no walkDone. The next walk starts at offset 0, index 0.
- R11: walkDone is a one-cycle pulse in the cycle after the final handshake or end decision of a completed walk.
- R12: skipMap has no effect in isochronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufActive | input | 1 | Buffer active/full gate |
| isoMode | input | 1 | 0 = fixed-block walk, 1 = isochronous walk |
| start | input | 1 | Begin a walk (when idle and active) |
| blockSize | input | BLK_W (11) | Fixed-mode payload block size in bytes |
| numDesc | input | CNT_W (5) | Fixed-mode descriptor count, 0..16 |
| skipMap | input | MAP_W (16) | Fixed-mode skip bitmap, bit i skips descriptor i |
| bufLen | input | OFF_W (16) | Isochronous buffer length in bytes |
| paySize | input | PAY_W (10) | Isochronous payload size in bytes |
| payLast | input | 1 | Marks the final isochronous payload |
| payValid | input | 1 | Payload size valid |
| payReady | output | 1 | Payload size accepted |
| descValid | output | 1 | Descriptor offset/index valid |
| descReady | input | 1 | Downstream accepts descriptor |
| descOffset | output | OFF_W (16) | Byte offset of descriptor |
| descIndex | output | IDX_W (8) | Descriptor index |
| walkDone | output | 1 | One-cycle pulse at walk completion |

## Verification
The assertions watch, on every cycle, the output handshake rules: valid held with stable data, no payload acceptance while a descriptor is offered, and single-cycle done pulses. They also check that fixed-mode outputs sit on the stride grid, that skipped indices never appear, and that an output is never raised while the buffer is inactive. The isochronous offset accumulation, the exact-fit and overflow boundaries of the buffer length, the last-flag ending, abort with restart from zero, and the complete sequence of visited indices are all checked only by the bench. It compares each walk against an independent model, with random backpressure on both handshakes.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int HDR_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIX,
    ST_ISO_WAIT,
    ST_ISO_EMIT
  } walkState_t;

  typedef struct packed {
    logic clear;   // return offset/index to zero
    logic advFix;  // step by fixed stride
    logic advIso;  // step by header + rounded payload
    logic capPay;  // latch incoming payload size/last
  } dpStrobe_t;
endpackage

// File: rtl/tdw_dpath.sv
module tdw_dpath
  import tdw_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int IDX_W = 8,
  parameter int PAY_W = 10,
  parameter int BLK_W = 11,
  parameter int MAP_W = 16,
  parameter int CNT_W = $clog2(MAP_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BLK_W-1:0] blockSize,
  input  logic [CNT_W-1:0] numDesc,
  input  logic [MAP_W-1:0] skipMap,
  input  logic [OFF_W-1:0] bufLen,
  input  logic [PAY_W-1:0] paySize,
  input  logic             payLast,
  output logic [OFF_W-1:0] curOffset,
  output logic [IDX_W-1:0] curIndex,
  output logic             skipCur,
  output logic             fixLast,
  output logic             zeroDesc,
  output logic             isoFits,
  output logic             capLast
);
  localparam int MAP_IW = $clog2(MAP_W);
  localparam int EW     = OFF_W + 1;

  logic [OFF_W-1:0] offReg;
  logic [IDX_W-1:0] idxReg;
  logic [PAY_W-1:0] paySzReg;
  logic             payLastReg;

  logic [EW-1:0]    stride;
  logic [PAY_W:0]   padSum;
  logic [PAY_W:0]   payRound;
  logic [EW-1:0]    isoEnd;

  always_comb begin
    stride   = EW'(blockSize) + EW'(HDR_BYTES);
    padSum   = {1'b0, paySzReg} + (PAY_W + 1)'(3);
    payRound = {padSum[PAY_W:2], 2'b00};
    isoEnd   = EW'(offReg) + EW'(HDR_BYTES) + EW'(payRound);
  end

  assign isoFits   = (isoEnd <= EW'(bufLen));
  assign skipCur   = skipMap[idxReg[MAP_IW-1:0]];
  assign fixLast   = (IDX_W'(numDesc) == (idxReg + 1'b1));
  assign zeroDesc  = (numDesc == '0);
  assign capLast   = payLastReg;
  assign curOffset = offReg;
  assign curIndex  = idxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg     <= '0;
      idxReg     <= '0;
      paySzReg   <= '0;
      payLastReg <= 1'b0;
    end else begin
      if (strobe.clear) begin
        offReg <= '0;
        idxReg <= '0;
      end else if (strobe.advFix) begin
        offReg <= offReg + stride[OFF_W-1:0];
        idxReg <= idxReg + 1'b1;
      end else if (strobe.advIso) begin
        offReg <= isoEnd[OFF_W-1:0];
        idxReg <= idxReg + 1'b1;
      end
      if (strobe.capPay) begin
        paySzReg   <= paySize;
        payLastReg <= payLast;
      end
    end
  end
endmodule

// File: rtl/tdw_ctrl.sv
module tdw_ctrl
  import tdw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bufActive,
  input  logic      isoMode,
  input  logic      start,
  input  logic      payValid,
  input  logic      descReady,
  input  logic      skipCur,
  input  logic      fixLast,
  input  logic      zeroDesc,
  input  logic      isoFits,
  input  logic      capLast,
  output dpStrobe_t strobe,
  output logic      payReady,
  output logic      descValid,
  output logic      walkDone
);
  walkState_t state, stateNxt;
  logic heldValid;
  logic doneNxt;

  always_comb begin
    stateNxt  = state;
    strobe    = '0;
    payReady  = 1'b0;
    descValid = 1'b0;
    doneNxt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && bufActive) begin
          strobe.clear = 1'b1;
          if (isoMode) begin
            stateNxt = ST_ISO_WAIT;
          end else if (zeroDesc) begin
            doneNxt = 1'b1;
          end else begin
            stateNxt = ST_FIX;
          end
        end
      end
      default: begin
        if (!bufActive && !heldValid) begin
          // abort: nothing pending, drop back to the origin
          strobe.clear = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          unique case (state)
            ST_FIX: begin
              if (skipCur) begin
                strobe.advFix = 1'b1;
                if (fixLast) begin
                  strobe.clear = 1'b1;
                  doneNxt      = 1'b1;
                  stateNxt     = ST_IDLE;
                end
              end else begin
                descValid = 1'b1;
                if (descReady) begin
                  strobe.advFix = 1'b1;
                  if (fixLast) begin
                    strobe.clear = 1'b1;
                    doneNxt      = 1'b1;
                    stateNxt     = ST_IDLE;
                  end
                end
              end
            end
            ST_ISO_WAIT: begin
              payReady = 1'b1;
              if (payValid) begin
                strobe.capPay = 1'b1;
                stateNxt      = ST_ISO_EMIT;
              end
            end
            ST_ISO_EMIT: begin
              if (!isoFits) begin
                strobe.clear = 1'b1;
                doneNxt      = 1'b1;
                stateNxt     = ST_IDLE;
              end else begin
                descValid = 1'b1;
                if (descReady) begin
                  strobe.advIso = 1'b1;
                  if (capLast) begin
                    strobe.clear = 1'b1;
                    doneNxt      = 1'b1;
                    stateNxt     = ST_IDLE;
                  end else begin
                    stateNxt = ST_ISO_WAIT;
                  end
                end
              end
            end
            default: stateNxt = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      heldValid <= 1'b0;
      walkDone  <= 1'b0;
    end else begin
      state     <= stateNxt;
      heldValid <= descValid && !descReady;
      walkDone  <= doneNxt;
    end
  end
endmodule

// File: rtl/tdWalker.sv
module tdWalker
  import tdw_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int IDX_W = 8,
  parameter int PAY_W = 10,
  parameter int BLK_W = 11,
  parameter int MAP_W = 16,
  parameter int CNT_W = $clog2(MAP_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bufActive,
  input  logic             isoMode,
  input  logic             start,
  input  logic [BLK_W-1:0] blockSize,
  input  logic [CNT_W-1:0] numDesc,
  input  logic [MAP_W-1:0] skipMap,
  input  logic [OFF_W-1:0] bufLen,
  input  logic [PAY_W-1:0] paySize,
  input  logic             payLast,
  input  logic             payValid,
  output logic             payReady,
  output logic             descValid,
  input  logic             descReady,
  output logic [OFF_W-1:0] descOffset,
  output logic [IDX_W-1:0] descIndex,
  output logic             walkDone
);
  dpStrobe_t strobe;
  logic skipCur, fixLast, zeroDesc, isoFits, capLast;

  tdw_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .bufActive (bufActive),
    .isoMode   (isoMode),
    .start     (start),
    .payValid  (payValid),
    .descReady (descReady),
    .skipCur   (skipCur),
    .fixLast   (fixLast),
    .zeroDesc  (zeroDesc),
    .isoFits   (isoFits),
    .capLast   (capLast),
    .strobe    (strobe),
    .payReady  (payReady),
    .descValid (descValid),
    .walkDone  (walkDone)
  );

  tdw_dpath #(
    .OFF_W (OFF_W),
    .IDX_W (IDX_W),
    .PAY_W (PAY_W),
    .BLK_W (BLK_W),
    .MAP_W (MAP_W),
    .CNT_W (CNT_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .blockSize (blockSize),
    .numDesc   (numDesc),
    .skipMap   (skipMap),
    .bufLen    (bufLen),
    .paySize   (paySize),
    .payLast   (payLast),
    .curOffset (descOffset),
    .curIndex  (descIndex),
    .skipCur   (skipCur),
    .fixLast   (fixLast),
    .zeroDesc  (zeroDesc),
    .isoFits   (isoFits),
    .capLast   (capLast)
  );
endmodule

// File: rtl/tdw_checker.sv
module tdw_checker #(
  parameter int OFF_W = 16,
  parameter int IDX_W = 8,
  parameter int BLK_W = 11,
  parameter int MAP_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             bufActive,
  input logic             isoMode,
  input logic [BLK_W-1:0] blockSize,
  input logic [MAP_W-1:0] skipMap,
  input logic             payReady,
  input logic             descValid,
  input logic             descReady,
  input logic [OFF_W-1:0] descOffset,
  input logic [IDX_W-1:0] descIndex,
  input logic             walkDone
);
  localparam int MAP_IW = $clog2(MAP_W);

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid);  // R9

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> $stable(descOffset) && $stable(descIndex));  // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);  // R11

  AST_HANDSHAKE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(payReady && descValid));  // R6

  AST_INACTIVE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !bufActive |-> $past(descValid && !descReady));  // R10

  AST_SKIP_HONOURED: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !isoMode |-> !skipMap[descIndex[MAP_IW-1:0]]);  // R3

  AST_FIX_GRID: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !isoMode |->
      descOffset == OFF_W'(32'(descIndex) * (32'(blockSize) + 32'd8)));  // R2
endmodule

bind tdWalker tdw_checker #(
  .OFF_W (OFF_W),
  .IDX_W (IDX_W),
  .BLK_W (BLK_W),
  .MAP_W (MAP_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .bufActive  (bufActive),
  .isoMode    (isoMode),
  .blockSize  (blockSize),
  .skipMap    (skipMap),
  .payReady   (payReady),
  .descValid  (descValid),
  .descReady  (descReady),
  .descOffset (descOffset),
  .descIndex  (descIndex),
  .walkDone   (walkDone)
);

// File: tb/sim_tdWalker.sv
module sim_tdWalker;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bufActive = 1'b0;
  logic        isoMode = 1'b0;
  logic        start = 1'b0;
  logic [10:0] blockSize = '0;
  logic [4:0]  numDesc = '0;
  logic [15:0] skipMap = '0;
  logic [15:0] bufLen = '0;
  logic [9:0]  paySize = '0;
  logic        payLast = 1'b0;
  logic        payValid = 1'b0;
  logic        payReady;
  logic        descValid;
  logic        descReady = 1'b0;
  logic [15:0] descOffset;
  logic [7:0]  descIndex;
  logic        walkDone;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int isoSz[16];

  always #(CLK_P / 2) clk = ~clk;

  tdWalker u0 (
    .clk(clk), .rstN(rstN), .bufActive(bufActive), .isoMode(isoMode),
    .start(start), .blockSize(blockSize), .numDesc(numDesc), .skipMap(skipMap),
    .bufLen(bufLen), .paySize(paySize), .payLast(payLast), .payValid(payValid),
    .payReady(payReady), .descValid(descValid), .descReady(descReady),
    .descOffset(descOffset), .descIndex(descIndex), .walkDone(walkDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int roundUp4(input int v);
    return (v + 3) / 4 * 4;
  endfunction

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    #1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R2 R3 R4 R11: fixed-block walk against a bench model
  task automatic runFix(input int blk, input int n, input int map, input int rdyPct);
    int expOff[16];
    int expIdx[16];
    int ne = 0;
    int got = 0;
    bit dn = 0;
    for (int i = 0; i < n; i++) begin
      if (map[i] == 1'b0) begin
        expOff[ne] = i * (blk + 8);
        expIdx[ne] = i;
        ne++;
      end
    end
    @(negedge clk);
    isoMode = 1'b0; blockSize = 11'(blk); numDesc = 5'(n); skipMap = 16'(map);
    descReady = 1'b0;
    pulseStart();
    for (int c = 0; c < 300 && !dn; c++) begin
      if (c > 0) @(negedge clk);
      descReady = (($urandom % 100) < rdyPct);
      #1;
      if (descValid && descReady) begin
        if (got < ne) begin
          chk(descOffset == 16'(expOff[got]), "R2 fixed offset", int'(descOffset), expOff[got]);
          chk(descIndex == 8'(expIdx[got]), "R3 visited index", int'(descIndex), expIdx[got]);
        end else begin
          chk(0, "R4 extra descriptor", int'(descIndex), -1);
        end
        got++;
      end
      if (walkDone) dn = 1;
    end
    chk(dn, "R4 walk done", int'(dn), 1);
    chk(got == ne, "R4 descriptor count", got, ne);
    @(negedge clk);
    descReady = 1'b0;
    #1;
    chk(!walkDone, "R11 done one cycle", int'(walkDone), 0);
  endtask

  // R5 R6 R7 R12: isochronous walk against a bench model
  task automatic runIso(input int cnt, input int bufL, input int lastAt, input int rdyPct);
    int expOff[16];
    int ne = 0;
    int off = 0;
    int got = 0;
    int fed = 0;
    bit dn = 0;
    bit acc = 0;
    for (int k = 0; k < cnt; k++) begin
      int e;
      e = off + 8 + roundUp4(isoSz[k]);
      if (e > bufL) break;
      expOff[ne] = off;
      ne++;
      off = e;
      if (k == lastAt) break;
    end
    @(negedge clk);
    isoMode = 1'b1; bufLen = 16'(bufL); skipMap = 16'hFFFF; payValid = 1'b0;
    pulseStart();
    for (int c = 0; c < 600 && !dn; c++) begin
      if (c > 0) @(negedge clk);
      if (acc) begin
        payValid = 1'b0;
        acc = 0;
      end
      if (!payValid && fed < cnt && (($urandom % 100) < 70)) begin
        payValid = 1'b1;
        paySize  = 10'(isoSz[fed]);
        payLast  = (fed == lastAt);
      end
      descReady = (($urandom % 100) < rdyPct);
      #1;
      chk(!(payReady && descValid), "R6 handshake exclusive", int'(payReady), 0);
      if (payValid && payReady) begin
        fed++;
        acc = 1;
      end
      if (descValid && descReady) begin
        if (got < ne) begin
          chk(descOffset == 16'(expOff[got]), "R5 iso offset", int'(descOffset), expOff[got]);
          chk(descIndex == 8'(got), "R12 iso index", int'(descIndex), got);
        end else begin
          chk(0, "R6 descriptor beyond end", int'(descOffset), -1);
        end
        got++;
      end
      if (walkDone) dn = 1;
    end
    chk(dn, "R7 iso walk done", int'(dn), 1);
    chk(got == ne, "R6 iso descriptor count", got, ne);
    @(negedge clk);
    payValid = 1'b0; descReady = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #1;
    chk(!descValid, "R1 reset descValid", int'(descValid), 0);
    chk(!payReady, "R1 reset payReady", int'(payReady), 0);
    chk(!walkDone, "R1 reset walkDone", int'(walkDone), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R8: start while inactive does nothing
    isoMode = 1'b0; numDesc = 5'd4; blockSize = 11'd32; skipMap = '0;
    pulseStart();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      #1;
      chk(!descValid && !walkDone && !payReady, "R8 inactive start ignored",
          int'({descValid, walkDone, payReady}), 0);
    end
    bufActive = 1'b1;

    // directed fixed cases
    runFix(32, 4, 0, 100);          // R2: second at 40
    runFix(32, 8, 16'h0011, 100);   // R3: 0 and 4 skipped
    runFix(32, 0, 0, 100);          // R4: empty walk
    runFix(4, 16, 16'h8001, 50);    // R3 edge bits
    runFix(0, 16, 16'hFFFF, 100);   // R3 everything skipped

    // R9 R10: hold and abort
    @(negedge clk);
    isoMode = 1'b0; blockSize = 11'd32; numDesc = 5'd8; skipMap = '0; descReady = 1'b0;
    pulseStart();
    #1;
    chk(descValid && descOffset == 16'd0, "R9 first offered", int'(descOffset), 0);
    @(negedge clk);
    bufActive = 1'b0;
    #1;
    chk(descValid, "R9 valid held while inactive", int'(descValid), 1);
    @(negedge clk);
    #1;
    chk(descValid && descOffset == 16'd0 && descIndex == 8'd0, "R9 data stable",
        int'(descOffset), 0);
    @(negedge clk);
    descReady = 1'b1;
    #1;
    @(negedge clk);
    #1;
    chk(!descValid, "R10 stopped after handshake", int'(descValid), 0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      #1;
      chk(!descValid && !walkDone, "R10 no output after abort",
          int'({descValid, walkDone}), 0);
    end
    bufActive = 1'b1;
    runFix(32, 3, 0, 100);          // R10 restart from offset 0

    // directed isochronous cases
    isoSz[0] = 200; isoSz[1] = 10; isoSz[2] = 1023; isoSz[3] = 30;
    runIso(4, 4000, 3, 100);        // R5 worked example, R7 last
    isoSz[0] = 4; isoSz[1] = 4; isoSz[2] = 4;
    runIso(3, 24, 2, 100);          // R6 exact fit then overflow
    runIso(3, 23, 2, 100);          // R6 second does not fit
    isoSz[0] = 1; isoSz[1] = 2; isoSz[2] = 3; isoSz[3] = 5;
    runIso(4, 1000, 1, 60);         // R7 early last

    // random mix
    for (int t = 0; t < 40; t++) begin
      runFix(int'($urandom % 2048), int'($urandom % 17), int'($urandom % 65536),
             30 + int'($urandom % 71));
    end
    for (int t = 0; t < 25; t++) begin
      int cnt;
      cnt = 1 + int'($urandom % 12);
      for (int k = 0; k < 16; k++) isoSz[k] = int'($urandom % 1024);
      runIso(cnt, 200 + int'($urandom % 9000), int'($urandom % cnt), 30 + int'($urandom % 71));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule